// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block lets logic on the host side set a digital step attenuator over a three-wire serial link. A client offers an attenuation value as a 6-bit count of 0.5 dB steps, using a valid/ready handshake. The block turns that count into the attenuator's active-low control code and shifts the code out, most significant bit first, on a serial clock and data line. It then pulses a latch-enable line so the attenuator applies the new setting.

All serial timing is produced by counting cycles of the faster system clock. The limits are given as parameters in picoseconds, next to the system clock period. The block rounds each limit up to a whole number of system cycles, so every minimum is met whatever the clock period. The data line changes only on the falling serial clock edge, or while the clock is idle and low. One frame runs at a time. A one-cycle done pulse marks the end of the latch, and ready returns high on the next cycle.

Top module: `atten_serial_master`

## Requirements
- R1: After reset, serClk, serData and serLatch are low, reqReady is high and xferDone is low.
- R2: reqReady is high only while no frame is in progress. A request is accepted on a clock edge where reqValid and reqReady are both high, and reqReady is low on the following cycle.
- R3: Each frame carries exactly six bits, most significant first, and each bit is valid at a rising edge of serClk. The code sent is the bitwise inverse of reqSteps: 0 steps sends 111111, 1 step sends 111110, and 63 steps sends 000000.
- R4: Each high phase of serClk lasts exactly HI_CYC = max(ceil(SCLK_HIGH_PS/SYS_PERIOD_PS), ceil(DATA_HOLD_PS/SYS_PERIOD_PS)) system cycles. Every rising edge follows at least LO_CYC = max(ceil(SCLK_LOW_PS/SYS_PERIOD_PS), ceil(DATA_SETUP_PS/SYS_PERIOD_PS)) low cycles. With the defaults both values are 10.
- R5: serData does not change while serClk is high, nor in the cycle in which serClk rises.
- R6: After the last falling edge of serClk, serLatch rises only after at least GAP_CYC cycles with serClk low (default 2). It then stays high for exactly PULSE_CYC cycles (default 6), and serClk stays low throughout.
- R7: xferDone is high for exactly one cycle: the first cycle after serLatch falls.
- R8: A request offered while a frame is in progress is ignored. It produces no frame, and reqReady stays low.
- R9: Between frames serClk, serData and serLatch are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqSteps | input | 6 | Requested attenuation in 0.5 dB steps |
| reqReady | output | 1 | Block is idle and can accept a request |
| serClk | output | 1 | Serial clock to the attenuator |
| serData | output | 1 | Serial data to the attenuator |
| serLatch | output | 1 | Latch enable to the attenuator |
| xferDone | output | 1 | One-cycle pulse when a frame has completed |

## Verification
Once a request is accepted, the first serial bit is on serData in the next cycle. The first rising edge of serClk comes LO_CYC cycles after acceptance, and each later bit takes LO_CYC + HI_CYC cycles. serLatch rises GAP_CYC cycles after the sixth falling edge and falls PULSE_CYC cycles later. xferDone follows in the next cycle, and reqReady rises one cycle after that.

The monitor samples on the falling system clock edge and finds each serial event by comparing the sample with the one before it. The length of every phase is measured from those events, so no check depends on a fixed absolute cycle. Each decoded code is compared, at the rising edge of serLatch, with the value at the front of the queue of expected codes.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_LEGAP, ST_LATCH, ST_FIN
  } serState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // capture inverted request into shifter
    logic shift;    // advance shifter (coincides with clock fall)
    logic clkRise;
    logic clkFall;
    logic leRise;
    logic leFall;
  } serStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_ser_ctrl.sv
module atten_ser_ctrl
  import atten_ser_pkg::*;
#(
  parameter int NBITS     = 6,
  parameter int HI_CYC    = 10,
  parameter int LO_CYC    = 10,
  parameter int GAP_CYC   = 2,
  parameter int PULSE_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       xferDone,
  output serStrobe_t strobe
);

  localparam int MAXC = maxOf(maxOf(HI_CYC, LO_CYC), maxOf(GAP_CYC, PULSE_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(NBITS + 1);

  serState_e state, nxt;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        nxt = ST_LOW;
      end
      ST_LOW: if (int'(cnt) == LO_CYC - 1) begin
        strobe.clkRise = 1'b1;
        nxt = ST_HIGH;
      end
      ST_HIGH: if (int'(cnt) == HI_CYC - 1) begin
        strobe.clkFall = 1'b1;
        strobe.shift   = 1'b1;
        nxt = (int'(bitIdx) == NBITS - 1) ? ST_LEGAP : ST_LOW;
      end
      ST_LEGAP: if (int'(cnt) == GAP_CYC - 1) begin
        strobe.leRise = 1'b1;
        nxt = ST_LATCH;
      end
      ST_LATCH: if (int'(cnt) == PULSE_CYC - 1) begin
        strobe.leFall = 1'b1;
        nxt = ST_FIN;
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (strobe.load)
        bitIdx <= '0;
      else if (strobe.shift)
        bitIdx <= bitIdx + 1'b1;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign xferDone = (state == ST_FIN);

  // R2: an accepted request makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7: done lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R8: while busy a new request cannot load the shifter
  p_busy_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !strobe.load);

endmodule

// File: rtl/atten_ser_dp.sv
module atten_ser_dp
  import atten_ser_pkg::*;
#(
  parameter int NBITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NBITS-1:0] reqSteps,
  input  serStrobe_t       strobe,
  input  logic             reqReady,
  input  logic             xferDone,
  output logic             serClk,
  output logic             serData,
  output logic             serLatch
);

  logic [NBITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      serClk   <= 1'b0;
      serLatch <= 1'b0;
    end else begin
      if (strobe.load)
        shiftReg <= ~reqSteps;            // active-low control code
      else if (strobe.shift)
        shiftReg <= {shiftReg[NBITS-2:0], 1'b0};
      if (strobe.clkRise)      serClk <= 1'b1;
      else if (strobe.clkFall) serClk <= 1'b0;
      if (strobe.leRise)       serLatch <= 1'b1;
      else if (strobe.leFall)  serLatch <= 1'b0;
    end
  end

  assign serData = shiftReg[NBITS-1];

  // R5: data holds steady while the serial clock is high or rising
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData));

  // R6: latch and clock never high together
  p_latch_clk_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    serLatch |-> !serClk);

  // R7: done follows the falling latch
  p_done_after_le_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> $fell(serLatch));

  // R9: idle lines are quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!serClk && !serLatch && !serData));

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_ser_pkg::*;
#(
  parameter int NBITS         = 6,
  parameter int SYS_PERIOD_PS = 5000,
  parameter int SCLK_HIGH_PS  = 50000,
  parameter int SCLK_LOW_PS   = 50000,
  parameter int DATA_SETUP_PS = 10000,
  parameter int DATA_HOLD_PS  = 10000,
  parameter int LE_GAP_PS     = 10000,
  parameter int LE_WIDTH_PS   = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [NBITS-1:0] reqSteps,
  output logic             reqReady,
  output logic             serClk,
  output logic             serData,
  output logic             serLatch,
  output logic             xferDone
);

  localparam int HI_CYC    = maxOf(1, maxOf(ceilDiv(SCLK_HIGH_PS, SYS_PERIOD_PS),
                                            ceilDiv(DATA_HOLD_PS, SYS_PERIOD_PS)));
  localparam int LO_CYC    = maxOf(1, maxOf(ceilDiv(SCLK_LOW_PS, SYS_PERIOD_PS),
                                            ceilDiv(DATA_SETUP_PS, SYS_PERIOD_PS)));
  localparam int GAP_CYC   = maxOf(1, ceilDiv(LE_GAP_PS, SYS_PERIOD_PS));
  localparam int PULSE_CYC = maxOf(1, ceilDiv(LE_WIDTH_PS, SYS_PERIOD_PS));

  serStrobe_t strobe;

  atten_ser_ctrl #(
    .NBITS(NBITS), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC),
    .GAP_CYC(GAP_CYC), .PULSE_CYC(PULSE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .xferDone(xferDone), .strobe(strobe)
  );

  atten_ser_dp #(.NBITS(NBITS)) dp_i (
    .clk(clk), .rstN(rstN), .reqSteps(reqSteps), .strobe(strobe),
    .reqReady(reqReady), .xferDone(xferDone),
    .serClk(serClk), .serData(serData), .serLatch(serLatch)
  );

endmodule

// File: tb/atten_serial_master_tb_top.sv
module atten_serial_master_tb_top;

  localparam int HIC = 10, LOWC = 10, GAPC = 2, PULSEC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [5:0] reqSteps = '0;
  logic reqReady, serClk, serData, serLatch, xferDone;

  always #2.5 clk = ~clk;

  atten_serial_master dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSteps(reqSteps),
    .reqReady(reqReady), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .xferDone(xferDone)
  );

  int checks = 0, errors = 0, frames = 0, pushed = 0, cycles = 0;
  bit finished = 0;
  logic [5:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: offers one request and pushes the expected code
  task automatic send(input logic [5:0] s);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqSteps = s;
    expQ.push_back(~s);
    pushed++;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R2 busy after accept", reqReady, 0);
  endtask

  // monitor state
  logic pSclk = 0, pSle = 0, pDone = 0, pData = 0;
  int hiCnt = 0, lowCnt = 0, leCnt = 0, bitCnt = 0;
  logic [5:0] capBits = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serClk && !pSclk) begin
        chk(lowCnt >= LOWC, "R4 low phase", lowCnt, LOWC);
        capBits = {capBits[4:0], serData};
        bitCnt++;
        hiCnt = 1;
      end else if (serClk) begin
        hiCnt++;
        chk(serData == pData, "R5 data stable while high", serData, pData);
      end
      if (!serClk && pSclk) begin
        chk(hiCnt == HIC, "R4 high phase", hiCnt, HIC);
        lowCnt = 1;
      end else if (!serClk) lowCnt++;
      if (serLatch && !pSle) begin
        chk(bitCnt == 6, "R3 bit count", bitCnt, 6);
        chk(lowCnt >= GAPC + 1, "R6 latch gap", lowCnt - 1, GAPC);
        if (expQ.size() == 0) chk(0, "R8 unexpected frame", capBits, 0);
        else begin
          logic [5:0] e;
          e = expQ.pop_front();
          chk(capBits == e, "R3 code", capBits, e);
        end
        frames++;
        bitCnt = 0;
        leCnt = 1;
      end else if (serLatch) begin
        leCnt++;
        chk(!serClk, "R6 clock low during latch", serClk, 0);
      end
      if (!serLatch && pSle) begin
        chk(leCnt == PULSEC, "R6 latch width", leCnt, PULSEC);
        chk(xferDone == 1'b1, "R7 done after latch fall", xferDone, 1);
      end else if (xferDone) begin
        chk(0, "R7 done misplaced", xferDone, 0);
      end
      if (xferDone && pDone) chk(0, "R7 done width", 2, 1);
      pSclk = serClk; pSle = serLatch; pDone = xferDone; pData = serData;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!serClk && !serData && !serLatch, "R1 lines low", {serClk, serData, serLatch}, 0);
    chk(reqReady == 1'b1, "R1 ready high", reqReady, 1);
    chk(xferDone == 1'b0, "R1 done low", xferDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && !serClk, "R1 after release", reqReady, 1);

    send(6'd0);    // R3 all ones
    send(6'd63);   // R3 all zeros
    send(6'd1);
    send(6'd42);
    send(6'd21);
    send(6'd32);

    // R8: request while busy is ignored
    send(6'd5);
    repeat (20) @(negedge clk);
    chk(reqReady == 1'b0, "R8 ready low while busy", reqReady, 0);
    reqValid = 1'b1;
    reqSteps = 6'd9;
    repeat (4) @(negedge clk);
    chk(reqReady == 1'b0, "R8 still busy", reqReady, 0);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(frames == pushed, "R8 frame count", frames, pushed);
    chk(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);
    chk(!serClk && !serData && !serLatch, "R9 idle lines", {serClk, serData, serLatch}, 0);
    finish_run();
  end

endmodule